// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sequences the attempts of one auxiliary-channel transfer. When a transfer command is accepted it pulses a launch strobe to an external transaction engine, then waits for that engine to report the attempt's outcome: a channel result, a reply code and a returned data-byte count. From these it decides whether to finish with success, give up, relaunch at once, or wait a fixed interval and then relaunch.

Each failure cause has its own budget. Short read acknowledgements, the three kinds of deferral that share one budget, downstream I2C deferrals, invalid replies and channel timeouts are counted separately, and some causes clear other counters. The two wait intervals are given in microseconds and turned into clock cycles through a clock-frequency parameter. A total attempt cap bounds the transfer whatever mix of causes occurs.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A transfer makes at most MAX_ATTEMPTS (default 7) launches; an outcome that would otherwise retry, reported on the last permitted attempt, ends the transfer with a failure.
- R2: A channel result of 0 (completed) resets both the timeout count and the invalid-reply count to zero.
- R3: With result 0 and reply code 0 (acknowledge) the transfer passes, unless it is a read (is_write low) whose att_bytes differs from req_len; that short case raises a short-ack count, fails when the count reaches 7, and otherwise holds waiting high for SHORT_WAIT_US*CLK_MHZ cycles before the next launch.
- R4: With result 0, reply codes 2 (channel defer), 3 (I2C NACK) and 4 (I2C defer) raise one shared defer count; it fails when the count reaches 7 and otherwise relaunches with no wait.
- R5: With result 0, reply code 5 (downstream I2C defer) resets the shared defer count and raises its own count, which fails when it reaches 7; otherwise it relaunches with no wait.
- R6: With result 0, reply code 1 (NACK), 6 (hot-plug lost) or any code from 7 to 15 fails at once; channel result 3 (disconnected) also fails at once.
- R7: Channel result 1 (invalid reply) fails on its second occurrence; otherwise waiting is held high for INVALID_WAIT_US*CLK_MHZ cycles before the next launch.
- R8: Channel result 2 (timeout) fails on its third occurrence; otherwise the next launch follows with no wait.
- R9: A start accepted while idle clears every cause count and the attempt count, so no count carries over from an earlier transfer.
- R10: launch is a one-cycle pulse in the cycle after start is accepted or after a wait ends; done is a one-cycle pulse in the cycle after the deciding att_done; pass is valid with done and held until the next start; att_done is ignored unless an attempt is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer command, accepted while idle |
| is_write | input | 1 | 1 for a write transfer, 0 for a read (captured at start) |
| req_len | input | LEN_W | Requested data bytes (captured at start) |
| att_done | input | 1 | Attempt outcome valid for one cycle |
| att_result | input | 2 | Channel result: 0 completed, 1 invalid, 2 timeout, 3 disconnected |
| att_reply | input | 4 | Reply code, meaningful when att_result is 0 |
| att_bytes | input | LEN_W | Data bytes returned by the attempt |
| launch | output | 1 | Start-attempt strobe to the transaction engine |
| waiting | output | 1 | High while an inter-retry wait runs |
| done | output | 1 | Transfer finished, one-cycle pulse |
| pass | output | 1 | Transfer outcome, 1 for success |

## Verification
Each reply code and channel result is driven alone to show its own budget and its own wait: counting launches and waiting cycles separates a relaunch with no wait (defer, timeout) from the 300 and 400 microsecond waits (short ack, invalid reply). Interleaved sequences then separate the clearing rules: timeouts or invalid replies split by a completed deferral must not add up, a downstream I2C defer must reset the shared defer budget, and a mix that exhausts no single budget must still stop at the attempt cap. Back-to-back transfers show that counts do not leak across a new start. A second instance with a larger attempt cap exposes per-cause limits that the default cap would otherwise mask.

// File: rtl/aux_retry_pkg.sv
`timescale 1ns/1ps
// Shared codes for the AUX retry controller.
// Assumes: channel results are 2 bits, reply codes are 4 bits.
package aux_retry_pkg;
    localparam logic [1:0] CH_OK      = 2'd0;
    localparam logic [1:0] CH_INVALID = 2'd1;
    localparam logic [1:0] CH_TIMEOUT = 2'd2;
    localparam logic [1:0] CH_DISCON  = 2'd3;

    localparam logic [3:0] RP_ACK        = 4'd0;
    localparam logic [3:0] RP_NACK       = 4'd1;
    localparam logic [3:0] RP_CH_DEFER   = 4'd2;
    localparam logic [3:0] RP_I2C_NACK   = 4'd3;
    localparam logic [3:0] RP_I2C_DEFER  = 4'd4;
    localparam logic [3:0] RP_BUS_DEFER  = 4'd5;
    localparam logic [3:0] RP_HPD_LOST   = 4'd6;

    typedef enum logic [2:0] {
        VD_PASS,
        VD_FAIL,
        VD_RETRY,
        VD_WAIT_SHORT,
        VD_WAIT_INVALID
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_AWAIT,
        ST_DELAY
    } ctrl_state_e;
endpackage

// File: rtl/aux_wait_timer.sv
`timescale 1ns/1ps
// Down-counter that times the inter-retry waits.
// Assumes: load arrives on the cycle the controller enters its delay state;
// busy stays high for exactly the selected number of cycles minus one, so
// the delay state lasts the full interval.
module aux_wait_timer #(
    parameter int SHORT_CYC = 60000,
    parameter int LONG_CYC  = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic busy
);
    localparam int WMAX = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int TW   = $clog2(WMAX + 1);
    localparam logic [TW-1:0] SHORT_LD = TW'(SHORT_CYC - 1);
    localparam logic [TW-1:0] LONG_LD  = TW'(LONG_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Load the interval, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= long_sel ? LONG_LD : SHORT_LD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R7
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && long_sel |=> cnt_q == LONG_LD);
endmodule

// File: rtl/aux_cause_tracker.sv
`timescale 1ns/1ps
// Per-cause retry budgets and the verdict for each attempt outcome.
// Assumes: eval is high for one cycle per outcome and never together with clear.
// The verdict ignores the total attempt cap; the controller applies it.
module aux_cause_tracker
    import aux_retry_pkg::*;
#(
    parameter int SHORT_LIMIT   = 7,
    parameter int DEFER_LIMIT   = 7,
    parameter int BUS_LIMIT     = 7,
    parameter int INVALID_LIMIT = 2,
    parameter int TIMEOUT_LIMIT = 3,
    parameter int CW            = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       eval,
    input  logic [1:0] result,
    input  logic [3:0] reply,
    input  logic       short_ack,
    output verdict_e   verdict
);
    localparam logic [CW-1:0] SL = CW'(SHORT_LIMIT);
    localparam logic [CW-1:0] DL = CW'(DEFER_LIMIT);
    localparam logic [CW-1:0] BL = CW'(BUS_LIMIT);
    localparam logic [CW-1:0] IL = CW'(INVALID_LIMIT);
    localparam logic [CW-1:0] TL = CW'(TIMEOUT_LIMIT);

    logic [CW-1:0] short_q, def_q, bus_q, inv_q, tmo_q;
    logic [CW-1:0] short_n, def_n, bus_n, inv_n, tmo_n;

    // Classify the outcome and work out the next count for each cause.
    always_comb begin
        verdict = VD_FAIL;
        short_n = short_q;
        def_n   = def_q;
        bus_n   = bus_q;
        inv_n   = inv_q;
        tmo_n   = tmo_q;
        case (result)
            CH_OK: begin
                inv_n = '0;
                tmo_n = '0;
                case (reply)
                    RP_ACK: begin
                        if (short_ack) begin
                            short_n = short_q + 1'b1;
                            verdict = (short_n >= SL) ? VD_FAIL : VD_WAIT_SHORT;
                        end else begin
                            verdict = VD_PASS;
                        end
                    end
                    RP_CH_DEFER, RP_I2C_NACK, RP_I2C_DEFER: begin
                        def_n   = def_q + 1'b1;
                        verdict = (def_n >= DL) ? VD_FAIL : VD_RETRY;
                    end
                    RP_BUS_DEFER: begin
                        def_n   = '0;
                        bus_n   = bus_q + 1'b1;
                        verdict = (bus_n >= BL) ? VD_FAIL : VD_RETRY;
                    end
                    default: verdict = VD_FAIL;
                endcase
            end
            CH_INVALID: begin
                inv_n   = inv_q + 1'b1;
                verdict = (inv_n >= IL) ? VD_FAIL : VD_WAIT_INVALID;
            end
            CH_TIMEOUT: begin
                tmo_n   = tmo_q + 1'b1;
                verdict = (tmo_n >= TL) ? VD_FAIL : VD_RETRY;
            end
            default: verdict = VD_FAIL;
        endcase
    end

    // Hold the counts; clear on a new transfer, update on each outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            short_q <= '0;
            def_q   <= '0;
            bus_q   <= '0;
            inv_q   <= '0;
            tmo_q   <= '0;
        end else if (eval) begin
            short_q <= short_n;
            def_q   <= def_n;
            bus_q   <= bus_n;
            inv_q   <= inv_n;
            tmo_q   <= tmo_n;
        end
    end

    // R2
    ok_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval && result == CH_OK |=> tmo_q == '0 && inv_q == '0);
    // R5
    bus_defer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval && result == CH_OK && reply == RP_BUS_DEFER |=> def_q == '0);
    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> short_q == '0 && def_q == '0 && bus_q == '0);
endmodule

// File: rtl/aux_retry_ctrl.sv
`timescale 1ns/1ps
// Retry sequencer for one auxiliary-channel transfer.
// Launches attempts, reads each outcome, and passes, fails, relaunches or
// waits. Assumes: the engine answers each launch with exactly one att_done;
// is_write and req_len are sampled when start is accepted.
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int CLK_MHZ         = 200,
    parameter int MAX_ATTEMPTS    = 7,
    parameter int SHORT_LIMIT     = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int BUS_LIMIT       = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3,
    parameter int SHORT_WAIT_US   = 300,
    parameter int INVALID_WAIT_US = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic             att_done,
    input  logic [1:0]       att_result,
    input  logic [3:0]       att_reply,
    input  logic [LEN_W-1:0] att_bytes,
    output logic             launch,
    output logic             waiting,
    output logic             done,
    output logic             pass
);
    localparam int L1   = (SHORT_LIMIT > DEFER_LIMIT) ? SHORT_LIMIT : DEFER_LIMIT;
    localparam int L2   = (BUS_LIMIT > INVALID_LIMIT) ? BUS_LIMIT : INVALID_LIMIT;
    localparam int L3   = (L1 > L2) ? L1 : L2;
    localparam int LMAX = (L3 > TIMEOUT_LIMIT) ? L3 : TIMEOUT_LIMIT;
    localparam int CW   = $clog2(LMAX + 1);
    localparam int AW   = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [AW-1:0] ACAP = AW'(MAX_ATTEMPTS);

    ctrl_state_e      state_q;
    logic [AW-1:0]    attempts_q;
    logic             wr_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q, pass_q;
    logic             accept, eval, short_ack, budget_left, t_busy, t_load;
    verdict_e         verdict;

    assign accept      = (state_q == ST_IDLE) && start;
    assign eval        = (state_q == ST_AWAIT) && att_done;
    assign short_ack   = !wr_q && (att_bytes != len_q);
    assign budget_left = (attempts_q < ACAP);
    assign t_load      = eval && budget_left &&
                         (verdict == VD_WAIT_SHORT || verdict == VD_WAIT_INVALID);

    aux_cause_tracker #(
        .SHORT_LIMIT  (SHORT_LIMIT),
        .DEFER_LIMIT  (DEFER_LIMIT),
        .BUS_LIMIT    (BUS_LIMIT),
        .INVALID_LIMIT(INVALID_LIMIT),
        .TIMEOUT_LIMIT(TIMEOUT_LIMIT),
        .CW           (CW)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .eval     (eval),
        .result   (att_result),
        .reply    (att_reply),
        .short_ack(short_ack),
        .verdict  (verdict)
    );

    aux_wait_timer #(
        .SHORT_CYC(SHORT_WAIT_US * CLK_MHZ),
        .LONG_CYC (INVALID_WAIT_US * CLK_MHZ)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .long_sel(verdict == VD_WAIT_INVALID),
        .busy    (t_busy)
    );

    // Transfer sequencing: accept, launch, await outcome, act on the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            attempts_q <= '0;
            wr_q       <= 1'b0;
            len_q      <= '0;
            done_q     <= 1'b0;
            pass_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q    <= ST_LAUNCH;
                    attempts_q <= '0;
                    wr_q       <= is_write;
                    len_q      <= req_len;
                    pass_q     <= 1'b0;
                end
                ST_LAUNCH: begin
                    attempts_q <= attempts_q + 1'b1;
                    state_q    <= ST_AWAIT;
                end
                ST_AWAIT: if (att_done) begin
                    case (verdict)
                        VD_PASS: begin
                            done_q  <= 1'b1;
                            pass_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        VD_FAIL: begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        default: begin
                            if (!budget_left) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else if (verdict == VD_RETRY) begin
                                state_q <= ST_LAUNCH;
                            end else begin
                                state_q <= ST_DELAY;
                            end
                        end
                    endcase
                end
                ST_DELAY: if (!t_busy) state_q <= ST_LAUNCH;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign launch  = (state_q == ST_LAUNCH);
    assign waiting = (state_q == ST_DELAY);
    assign done    = done_q;
    assign pass    = pass_q;

    // R10
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);
    // R1
    attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempts_q <= ACAP);
    // R6
    nack_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval && att_result == CH_OK && att_reply == RP_NACK |=> done && !pass);
    // R8
    timeout_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval && att_result == CH_TIMEOUT |=> !waiting);
    // R7
    invalid_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval && att_result == CH_INVALID |=> waiting || (done && !pass));
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !launch && !waiting);
endmodule

// File: tb/tb_aux_retry_ctrl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; a scripted engine answers each launch.
module tb_aux_retry_ctrl;
    localparam int LW = 5;
    localparam int MHZ = 2;            // shortens waits: 300 us -> 600 cycles
    localparam int SW  = 300 * MHZ;
    localparam int IW  = 400 * MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_m = 1'b0, start_w = 1'b0;
    logic is_write = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic att_done = 1'b0;
    logic [1:0] att_result = '0;
    logic [3:0] att_reply = '0;
    logic [LW-1:0] att_bytes = '0;
    logic launch_m, waiting_m, done_m, pass_m;
    logic launch_w, waiting_w, done_w, pass_w;

    int n_checks = 0;
    int n_fail = 0;

    logic [1:0]    q_res [0:15];
    logic [3:0]    q_rep [0:15];
    logic [LW-1:0] q_byt [0:15];
    int got_l, got_w, got_p;

    always #2.5 clk = ~clk;

    aux_retry_ctrl #(.LEN_W(LW), .CLK_MHZ(MHZ)) dut (
        .clk(clk), .rst_n(rst_n), .start(start_m), .is_write(is_write),
        .req_len(req_len), .att_done(att_done), .att_result(att_result),
        .att_reply(att_reply), .att_bytes(att_bytes),
        .launch(launch_m), .waiting(waiting_m), .done(done_m), .pass(pass_m));

    aux_retry_ctrl #(.LEN_W(LW), .CLK_MHZ(MHZ), .MAX_ATTEMPTS(16)) dut_wide (
        .clk(clk), .rst_n(rst_n), .start(start_w), .is_write(is_write),
        .req_len(req_len), .att_done(att_done), .att_result(att_result),
        .att_reply(att_reply), .att_bytes(att_bytes),
        .launch(launch_w), .waiting(waiting_w), .done(done_w), .pass(pass_w));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [1:0] r, input logic [3:0] c, input int b);
        q_res[i] = r;
        q_rep[i] = c;
        q_byt[i] = LW'(b);
    endtask

    // Run one transfer; count launches and waiting cycles, record pass.
    task automatic run(input bit wide, input bit wr, input int len);
        int k = 0;
        bit pend = 0;
        bit fin = 0;
        int guard = 0;
        got_l = 0; got_w = 0; got_p = -1;
        @(negedge clk);
        is_write = wr;
        req_len = LW'(len);
        if (wide) start_w = 1'b1; else start_m = 1'b1;
        @(negedge clk);
        start_w = 1'b0; start_m = 1'b0;
        while (!fin && guard < 20000) begin
            if (wide ? done_w : done_m) begin
                fin = 1;
                got_p = int'(wide ? pass_w : pass_m);
            end else begin
                if (att_done) att_done = 1'b0;
                else if (pend) begin
                    att_result = q_res[k];
                    att_reply  = q_rep[k];
                    att_bytes  = q_byt[k];
                    att_done   = 1'b1;
                    k++;
                    pend = 0;
                end
                if (wide ? launch_w : launch_m) begin
                    got_l++;
                    pend = 1;
                end
                if (wide ? waiting_w : waiting_m) got_w++;
                @(negedge clk);
                guard++;
            end
        end
        att_done = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10", "launch after reset", int'(launch_m), 0);
        chk("R10", "done after reset", int'(done_m), 0);
        chk("R10", "pass after reset", int'(pass_m), 0);
        chk("R10", "waiting after reset", int'(waiting_m), 0);
        @(negedge clk); att_done = 1'b1;
        @(negedge clk); att_done = 1'b0;
        @(negedge clk);
        chk("R10", "stray att_done launch", int'(launch_m), 0);
        chk("R10", "stray att_done done", int'(done_m), 0);
    endtask

    task automatic t_ack;
        put(0, 2'd0, 4'd0, 0);
        run(0, 1, 4);
        chk("R3", "write ack pass", got_p, 1);
        chk("R3", "write ack launches", got_l, 1);
        @(negedge clk);
        chk("R10", "pass held", int'(pass_m), 1);
        chk("R10", "done one cycle", int'(done_m), 0);
        put(0, 2'd0, 4'd0, 4);
        run(0, 0, 4);
        chk("R3", "full read pass", got_p, 1);
        put(0, 2'd0, 4'd0, 2); put(1, 2'd0, 4'd0, 4);
        run(0, 0, 4);
        chk("R3", "short then full pass", got_p, 1);
        chk("R3", "short then full launches", got_l, 2);
        chk("R3", "short wait cycles", got_w, SW);
    endtask

    task automatic t_short_budget;
        for (int i = 0; i < 7; i++) put(i, 2'd0, 4'd0, 1);
        put(7, 2'd0, 4'd0, 3);
        run(1, 0, 3);
        chk("R3", "short budget fail", got_p, 0);
        chk("R3", "short budget launches", got_l, 7);
        chk("R3", "short budget waits", got_w, 6 * SW);
    endtask

    task automatic t_immediate;
        put(0, 2'd0, 4'd1, 0); put(1, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R6", "nack fail", got_p, 0);
        chk("R6", "nack launches", got_l, 1);
        put(0, 2'd0, 4'd6, 0);
        run(0, 1, 1);
        chk("R6", "hpd code launches", got_l, 1);
        put(0, 2'd0, 4'd11, 0);
        run(0, 1, 1);
        chk("R6", "unknown code fail", got_p, 0);
        chk("R6", "unknown code launches", got_l, 1);
        put(0, 2'd3, 4'd0, 0);
        run(0, 1, 1);
        chk("R6", "disconnect launches", got_l, 1);
    endtask

    task automatic t_timeout;
        for (int i = 0; i < 4; i++) put(i, 2'd2, 4'd0, 0);
        run(0, 1, 1);
        chk("R8", "timeout fail", got_p, 0);
        chk("R8", "timeout launches", got_l, 3);
        chk("R8", "timeout no wait", got_w, 0);
        put(0, 2'd2, 4'd0, 0); put(1, 2'd2, 4'd0, 0); put(2, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R8", "two timeouts then ack", got_p, 1);
        chk("R8", "two timeouts launches", got_l, 3);
    endtask

    task automatic t_invalid;
        put(0, 2'd1, 4'd0, 0); put(1, 2'd1, 4'd0, 0); put(2, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R7", "invalid twice fail", got_p, 0);
        chk("R7", "invalid twice launches", got_l, 2);
        chk("R7", "invalid wait cycles", got_w, IW);
        put(0, 2'd1, 4'd0, 0); put(1, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R7", "invalid then ack", got_p, 1);
    endtask

    task automatic t_clearing;
        put(0, 2'd1, 4'd0, 0); put(1, 2'd0, 4'd2, 0);
        put(2, 2'd1, 4'd0, 0); put(3, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R2", "invalid split by ok", got_p, 1);
        chk("R2", "invalid split launches", got_l, 4);
        chk("R2", "invalid split waits", got_w, 2 * IW);
        put(0, 2'd2, 4'd0, 0); put(1, 2'd2, 4'd0, 0); put(2, 2'd0, 4'd4, 0);
        put(3, 2'd2, 4'd0, 0); put(4, 2'd2, 4'd0, 0); put(5, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R2", "timeouts split by ok", got_p, 1);
        chk("R2", "timeouts split launches", got_l, 6);
    endtask

    task automatic t_defer;
        put(0, 2'd0, 4'd2, 0); put(1, 2'd0, 4'd3, 0); put(2, 2'd0, 4'd4, 0);
        put(3, 2'd0, 4'd2, 0); put(4, 2'd0, 4'd3, 0); put(5, 2'd0, 4'd4, 0);
        put(6, 2'd0, 4'd2, 0); put(7, 2'd0, 4'd0, 0);
        run(1, 1, 1);
        chk("R4", "shared defer fail", got_p, 0);
        chk("R4", "shared defer launches", got_l, 7);
        chk("R4", "shared defer no wait", got_w, 0);
        for (int i = 0; i < 6; i++) put(i, 2'd0, 4'd2, 0);
        put(6, 2'd0, 4'd5, 0);
        for (int i = 7; i < 13; i++) put(i, 2'd0, 4'd2, 0);
        put(13, 2'd0, 4'd0, 0);
        run(1, 1, 1);
        chk("R5", "bus defer resets defer", got_p, 1);
        chk("R5", "bus defer reset launches", got_l, 14);
        for (int i = 0; i < 8; i++) put(i, 2'd0, 4'd5, 0);
        run(1, 1, 1);
        chk("R5", "bus defer budget fail", got_p, 0);
        chk("R5", "bus defer budget launches", got_l, 7);
    endtask

    task automatic t_cap;
        put(0, 2'd2, 4'd0, 0); put(1, 2'd2, 4'd0, 0); put(2, 2'd0, 4'd2, 0);
        put(3, 2'd2, 4'd0, 0); put(4, 2'd2, 4'd0, 0); put(5, 2'd0, 4'd2, 0);
        put(6, 2'd0, 4'd2, 0); put(7, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R1", "attempt cap fail", got_p, 0);
        chk("R1", "attempt cap launches", got_l, 7);
        run(1, 1, 1);
        chk("R1", "wider cap passes", got_p, 1);
        chk("R1", "wider cap launches", got_l, 8);
    endtask

    task automatic t_restart;
        put(0, 2'd2, 4'd0, 0); put(1, 2'd2, 4'd0, 0); put(2, 2'd0, 4'd1, 0);
        run(0, 1, 1);
        chk("R9", "first transfer fail", got_p, 0);
        put(0, 2'd2, 4'd0, 0); put(1, 2'd0, 4'd0, 0);
        run(0, 1, 1);
        chk("R9", "counts cleared at start", got_p, 1);
        chk("R9", "counts cleared launches", got_l, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack();
        t_short_budget();
        t_immediate();
        t_timeout();
        t_invalid();
        t_clearing();
        t_defer();
        t_cap();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule